// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block steers the read path of a flash-style memory. A 16-bit configuration word chooses one of two read styles. In the asynchronous style, the incoming address goes straight through to the array and the word comes back in the same cycle. In the clocked burst style, the sequencer latches an address when the address strobe is low. It then waits a programmed number of clocks and streams one word per clock from the array. The stream ends after a fixed count of 4, 8 or 16 words, or it runs on with no end.

A fixed-length burst stays inside an aligned window of its own size and wraps at the window edge. A continuous burst steps upward through the whole address space. A read flagged as identifier space does not touch the array. It returns the configuration word when the low address byte is 0x05 and zero for any other offset, and it repeats that same word on every beat of the burst. Reset returns the configuration to the asynchronous style.

The outgoing word stream has a valid/ready pair. A word counts as taken only on a clock edge where `dout_valid_o` and `dout_ready_i` are both high. While ready is low, the address and the word are held unchanged. Output enable works the same way: it gates valid and so stalls the stream.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration word is 0x9807. In that word, bit 15 = 1 selects the asynchronous style, bits 14:11 = 3 are the wait count, and bits 2:0 = 111 select the continuous length. The sequencer is idle.
- R2: A clock edge with `cfg_we_i` high loads `cfg_wdata_i`. An identifier-space read at offset 0x05 returns the stored word. Any other identifier offset returns 0.
- R3: With bit 15 set, `arr_addr_o` equals `addr_i` and `dout_valid_o` equals `!ce_n && !oe_n` in the same cycle. The address strobe `adv_n` has no effect.
- R4: With bit 15 clear, a rising edge with `ce_n` and `adv_n` both low captures the address, the identifier flag and the length code. Let L be bits 14:11 (an L of 0 acts as 1). The first word is valid in the cycle that follows the L-th rising edge after the capture edge.
- R5: Length code bits 2:0 of 001, 010 and 011 give 4, 8 and 16 words. After that many words are taken, `dout_valid_o` stays low until the next capture.
- R6: In a fixed-length burst of N words, beat i reads `(base & ~(N-1)) | ((base+i) & (N-1))`.
- R7: Any other length code runs continuously, and beat i reads `base+i` modulo 2^ADDR_W.
- R8: While `dout_valid_o` is high and `dout_ready_i` is low, or while `oe_n` is high, the address and the word do not advance.
- R9: In a burst captured with `id_space_i` high, every beat carries the same identifier word and `arr_rd_o` stays low.
- R10: `ce_n` high drops `dout_valid_o` in the same cycle and abandons the burst. Valid stays low until a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| addr_i | input | ADDR_W | Read address |
| id_space_i | input | 1 | Read from identifier space instead of the array |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write value |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_rd_o | output | 1 | Array read strobe |
| arr_rdata_i | input | 16 | Array word for `arr_addr_o`, same cycle |
| dout_data_o | output | 16 | Output word |
| dout_valid_o | output | 1 | Output word valid |
| dout_ready_i | input | 1 | Consumer takes the word |

## Verification
In the asynchronous style, the address and valid follow the inputs within the same cycle, so the bench checks them one time unit after it drives them. In burst style, the first word is due after the L-th edge that follows the capture edge. The bench drives on falling edges and samples at each falling edge, and it expects valid to be low at every sample before the L-th one. Each later beat is due one edge after the previous word is taken, and the drop of valid is due one edge after the last word. A stall is checked by sampling the same address on consecutive falling edges while ready or output enable blocks acceptance.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W    = 16;
  localparam int MODE_BIT = 15;
  localparam int LAT_LSB  = 11;
  localparam int LAT_W    = 4;
  localparam int LEN_W    = 3;
  localparam int BEAT_W   = 5;
  localparam logic [CFG_W-1:0] CFG_RESET  = 16'h9807;
  localparam logic [7:0]       CFG_ID_OFS = 8'h05;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA} seq_st_e;

  typedef struct packed {
    logic             async_mode;
    logic [LAT_W-1:0] lat;
    logic [LEN_W-1:0] len;
  } cfg_f_t;

  // words per burst for a length code; zero means no end
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [LEN_W-1:0] code);
    case (code)
      3'b001:  return 5'd4;
      3'b010:  return 5'd8;
      3'b011:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output cfg_f_t           fields
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RESET;
    else if (we) cfg_q <= wdata;
  end

  assign fields.async_mode = cfg_q[MODE_BIT];
  assign fields.lat        = cfg_q[LAT_LSB +: LAT_W];
  assign fields.len        = cfg_q[LEN_W-1:0];
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc;
  logic [AW-1:0] nxt;

  // bits under the mask count, bits outside it stay put
  assign inc = addr_q + ONE;
  assign nxt = (addr_q & ~mask) | (inc & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= base;
    else if (step) addr_q <= nxt;
  end
endmodule

// File: rtl/brs_seq_ctrl.sv
module brs_seq_ctrl
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic             ce_n,
  input  logic             start,
  input  logic             accept,
  input  logic [LAT_W-1:0] lat,
  input  logic [LEN_W-1:0] len,
  output logic             st_data
);
  seq_st_e           st_q;
  logic [LAT_W-1:0]  wait_q;
  logic [BEAT_W-1:0] left_q;
  logic              cont_q;
  logic [BEAT_W-1:0] beats;

  assign beats = burst_beats(len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      left_q <= '0;
      cont_q <= 1'b0;
    end else if (!sync_en || ce_n) begin
      st_q <= ST_IDLE;
    end else if (start) begin
      st_q   <= ST_WAIT;
      wait_q <= (lat == '0) ? LAT_W'(1) : lat;
      left_q <= beats;
      cont_q <= (beats == '0);
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (wait_q == LAT_W'(1)) st_q <= ST_DATA;
          else                     wait_q <= wait_q - LAT_W'(1);
        end
        ST_DATA: begin
          if (accept) begin
            if (!cont_q && left_q == BEAT_W'(1)) st_q <= ST_IDLE;
            else if (!cont_q)                    left_q <= left_q - BEAT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_data = (st_q == ST_DATA);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_space_i,
  input  logic              cfg_we_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic              arr_rd_o,
  input  logic [15:0]       arr_rdata_i,
  output logic [15:0]       dout_data_o,
  output logic              dout_valid_o,
  input  logic              dout_ready_i
);
  logic [CFG_W-1:0]  cfg_q;
  cfg_f_t            cfg_f;
  logic              async_mode;
  logic              start;
  logic              accept;
  logic              st_data;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] mask_nxt;
  logic [BEAT_W-1:0] beats;
  logic              id_q;
  logic              id_hit_q;
  logic              use_id;
  logic              use_hit;

  brs_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we_i),
    .wdata (cfg_wdata_i),
    .cfg_q (cfg_q),
    .fields(cfg_f)
  );

  assign async_mode = cfg_f.async_mode;
  assign start      = !async_mode && !ce_n && !adv_n;
  assign accept     = dout_valid_o && dout_ready_i;
  assign beats      = burst_beats(cfg_f.len);
  assign mask_nxt   = (beats == '0) ? '1 : ADDR_W'(beats - BEAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      win_mask <= '0;
      id_q     <= 1'b0;
      id_hit_q <= 1'b0;
    end else if (start) begin
      base_q   <= addr_i;
      win_mask <= mask_nxt;
      id_q     <= id_space_i;
      id_hit_q <= (addr_i[7:0] == CFG_ID_OFS);
    end
  end

  brs_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_en(!async_mode),
    .ce_n   (ce_n),
    .start  (start),
    .accept (accept),
    .lat    (cfg_f.lat),
    .len    (cfg_f.len),
    .st_data(st_data)
  );

  brs_addr_gen #(.AW(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .base  (addr_i),
    .step  (accept && !async_mode),
    .mask  (win_mask),
    .addr_q(addr_q)
  );

  assign use_id  = async_mode ? id_space_i : id_q;
  assign use_hit = async_mode ? (addr_i[7:0] == CFG_ID_OFS) : id_hit_q;

  assign arr_addr_o   = async_mode ? addr_i : addr_q;
  assign dout_valid_o = !ce_n && !oe_n && (async_mode || st_data);
  assign arr_rd_o     = dout_valid_o && !use_id;
  assign dout_data_o  = use_id ? (use_hit ? cfg_q : '0) : arr_rdata_i;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          adv_n,
  input logic          cfg_we,
  input logic          dout_valid,
  input logic          dout_ready,
  input logic [AW-1:0] arr_addr,
  input logic          async_mode,
  input logic          st_data,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] win_mask
);
  p_valid_needs_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !ce_n);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && adv_n && !cfg_we && !async_mode) |=> $stable(arr_addr));

  p_capture_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !ce_n && !adv_n && !cfg_we) |=> !dout_valid);

  p_window_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data && !async_mode) |-> (((arr_addr ^ base_q) & ~win_mask) == '0));
endmodule

bind burst_read_seq brs_checker #(.AW(ADDR_W)) u_brs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .adv_n     (adv_n),
  .cfg_we    (cfg_we_i),
  .dout_valid(dout_valid_o),
  .dout_ready(dout_ready_i),
  .arr_addr  (arr_addr_o),
  .async_mode(async_mode),
  .st_data   (st_data),
  .base_q    (base_q),
  .win_mask  (win_mask)
);

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;
  localparam int AW = 16;
  localparam int NV = 8;
  // {id, beats to check, config word, start address}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'd4,  16'h1001, 16'h0106},
    {1'b0, 8'd8,  16'h2002, 16'h00FD},
    {1'b0, 8'd16, 16'h0803, 16'h123A},
    {1'b0, 8'd20, 16'h0007, 16'hFFFE},
    {1'b0, 8'd18, 16'h1000, 16'h0010},
    {1'b1, 8'd8,  16'h1802, 16'h0005},
    {1'b1, 8'd4,  16'h0801, 16'h0009},
    {1'b0, 8'd4,  16'h7801, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          id_space = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [AW-1:0] arr_addr;
  logic          arr_rd;
  logic [15:0]   arr_rdata;
  logic [15:0]   dout_data;
  logic          dout_valid;
  logic          dout_ready = 1'b1;
  int            n_chk = 0;
  int            n_bad = 0;

  always #10 clk = ~clk;

  assign arr_rdata = arr_addr ^ 16'h5A5A;

  burst_read_seq #(.ADDR_W(AW)) u_burst_read_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
    .addr_i(addr_i), .id_space_i(id_space), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .arr_addr_o(arr_addr), .arr_rd_o(arr_rd), .arr_rdata_i(arr_rdata),
    .dout_data_o(dout_data), .dout_valid_o(dout_valid), .dout_ready_i(dout_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int i,
                                             input logic [2:0] code);
    int n;
    logic [AW-1:0] m;
    n = (code == 3'b001) ? 4 : (code == 3'b010) ? 8 : (code == 3'b011) ? 16 : 0;
    if (n == 0) return base + AW'(i);
    m = AW'(n - 1);
    return (base & ~m) | ((base + AW'(i)) & m);
  endfunction

  task automatic run_burst(input logic [15:0] cfg, input logic [AW-1:0] a,
                           input logic id, input int nb);
    int lat;
    logic fixed;
    logic [AW-1:0] ea;
    lat   = (cfg[14:11] == 4'd0) ? 1 : int'(cfg[14:11]);
    fixed = (cfg[2:0] == 3'b001) || (cfg[2:0] == 3'b010) || (cfg[2:0] == 3'b011);
    wr_cfg(cfg);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr_i = a; id_space = id; dout_ready = 1'b1;
    @(negedge clk); adv_n = 1'b1;
    chk("R4 wait after capture", 32'(dout_valid), 32'd0);
    for (int j = 1; j < lat; j++) begin
      @(negedge clk);
      chk("R4 latency", 32'(dout_valid), 32'd0);
    end
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      chk("R4 word valid", 32'(dout_valid), 32'd1);
      if (id) begin
        chk("R9 repeated word", 32'(dout_data), (a[7:0] == 8'h05) ? 32'(cfg) : 32'd0);
        chk("R9 no array read", 32'(arr_rd), 32'd0);
      end else begin
        ea = exp_addr(a, i, cfg[2:0]);
        chk(fixed ? "R6 wrap address" : "R7 linear address", 32'(arr_addr), 32'(ea));
        chk("R6 word", 32'(dout_data), 32'(ea ^ 16'h5A5A));
      end
    end
    if (fixed) begin
      @(negedge clk);
      chk("R5 burst end", 32'(dout_valid), 32'd0);
    end
    ce_n = 1'b1; oe_n = 1'b1; id_space = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 idle in reset", 32'(dout_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; id_space = 1'b1; addr_i = 16'h0005;
    #1 chk("R1 reset config", 32'(dout_data), 32'h9807);
    // asynchronous style, strobe ignored
    id_space = 1'b0; oe_n = 1'b1; adv_n = 1'b0; addr_i = 16'h0ABC;
    @(negedge clk); adv_n = 1'b1;
    chk("R3 oe gates valid", 32'(dout_valid), 32'd0);
    oe_n = 1'b0;
    #1 chk("R3 async valid", 32'(dout_valid), 32'd1);
    chk("R3 async address", 32'(arr_addr), 32'h0ABC);
    chk("R3 async word", 32'(dout_data), 32'h0ABC ^ 32'h5A5A);
    addr_i = 16'h0123;
    #1 chk("R3 address follows", 32'(arr_addr), 32'h0123);
    ce_n = 1'b1; oe_n = 1'b1;
    // configuration write and readback
    wr_cfg(16'hC00A);
    ce_n = 1'b0; oe_n = 1'b0; id_space = 1'b1; addr_i = 16'h0005;
    #1 chk("R2 readback", 32'(dout_data), 32'hC00A);
    addr_i = 16'h0006;
    #1 chk("R2 other offset", 32'(dout_data), 32'd0);
    ce_n = 1'b1; oe_n = 1'b1; id_space = 1'b0;

    for (int v = 0; v < NV; v++)
      run_burst(VEC[v][31:16], VEC[v][15:0], VEC[v][40], int'(VEC[v][39:32]));

    // back-pressure
    wr_cfg(16'h0803);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr_i = 16'h0040; dout_ready = 1'b0;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk);
    chk("R8 first word", 32'(arr_addr), 32'h0040);
    @(negedge clk);
    chk("R8 ready low holds", 32'(arr_addr), 32'h0040);
    dout_ready = 1'b1;
    @(negedge clk);
    chk("R8 advance", 32'(arr_addr), 32'h0041);
    oe_n = 1'b1;
    #1 chk("R8 oe drops valid", 32'(dout_valid), 32'd0);
    @(negedge clk);
    chk("R8 oe holds", 32'(arr_addr), 32'h0041);
    oe_n = 1'b0; ce_n = 1'b1;

    // chip-enable abort
    wr_cfg(16'h0801);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr_i = 16'h0080;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk);
    chk("R10 word before abort", 32'(dout_valid), 32'd1);
    ce_n = 1'b1;
    #1 chk("R10 valid drops", 32'(dout_valid), 32'd0);
    @(negedge clk); ce_n = 1'b0;
    #1 chk("R10 stays idle", 32'(dout_valid), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no resume", 32'(dout_valid), 32'd0);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    report();
  end
endmodule